// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A tester drives a test clock, a mode-select line and a serial data input. The block walks the standard sixteen-state test-port state machine and selects one serial register between data-in and data-out. The register is chosen by a 5-bit instruction. The selectable registers are a one-bit bypass stage, a 32-bit identification word, a 32-bit user code word and a boundary chain around the pads. The port also gives access to two user-defined registers that live outside the block, and to a serial configuration stream in each direction.

The boundary chain covers `NUM_BIDIR` bidirectional pads followed by `NUM_INONLY` input-only pads. A bidirectional pad holds three cells and an input-only pad holds one. The chain has a capture/shift stage and a separate update stage. The pads are driven from the update stage only under the external-test instruction. One instruction floats every pad, and another advances a start-up sequencer once per test clock while data is shifted. Serial output changes on the falling test-clock edge and is enabled only while a register is shifting.

Top module: `scan_port_ctrl`

## Requirements
- R1: The state machine follows the standard sixteen-state transition graph, sampling `tms` on the rising edge of `tck`. `trstN` low forces Test-Logic-Reset at once, and five rising edges with `tms` high reach Test-Logic-Reset from any state.
- R2: The instruction register is 5 bits wide and is shifted least significant bit first. In Capture-IR its shift stage loads 5'b00001, it takes the shifted value in Update-IR, and in Test-Logic-Reset it loads the identification opcode 5'b01001.
- R3: The opcodes are: 00000 external test, 00001 sample, 00010 user register 1, 00011 user register 2, 00100 configuration read, 00101 configuration write, 00111 internal test, 01000 user code, 01001 identification, 01010 float pads, 01100 start-up step, 11111 bypass. Every other code selects the bypass stage.
- R4: The bypass stage is one bit wide and captures 0, so data leaves `tdo` one shift later than it enters on `tdi`.
- R5: The identification and user code registers capture the `IDCODE_VAL` and `USERCODE_VAL` parameters and shift them out least significant bit first.
- R6: Boundary cell 0 is nearest `tdo`. Bidirectional pad p owns cell 3p (pad input), cell 3p+1 (core output) and cell 3p+2 (core output enable, 1 = drive). Input-only pad k owns cell 3*NUM_BIDIR+k and reads `padIn[NUM_BIDIR+k]`. The chain is captured under external test, sample and internal test.
- R7: Update-DR under a boundary instruction copies each pad's output and enable cells into the update stage. `padOut`/`padOe` follow that stage only under external test. Otherwise they pass `coreOut`/`coreOe` through.
- R8: Under float pads, every `padOe` bit is 0 and `tdi` reaches `tdo` through the bypass stage.
- R9: `userReset`, `userUpdate` and `userShift` are high exactly in Test-Logic-Reset, Update-DR and Shift-DR. `user1Sel`/`user2Sel` flag the two user instructions, during which `tdo` carries `userTdo1`/`userTdo2`.
- R10: Under start-up step, `startupStep` is high for each `tck` cycle spent in Shift-DR and low at all other times.
- R11: Under configuration write, `cfgInStrobe` is high in each Shift-DR cycle, marking `tdi` as a stream bit, and the bypass stage feeds `tdo`. Under configuration read, `tdo` carries `cfgOutData`.
- R12: `tdo` and `tdoEn` change only on falling `tck` edges, and `tdoEn` is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdoEn | output | 1 | Output enable for tdo |
| padIn | input | NUM_BIDIR+NUM_INONLY | Levels seen at the pads |
| coreOut | input | NUM_BIDIR | Core output data per bidirectional pad |
| coreOe | input | NUM_BIDIR | Core output enable per bidirectional pad |
| padOut | output | NUM_BIDIR | Data to the pad drivers |
| padOe | output | NUM_BIDIR | Enable to the pad drivers |
| userTdo1 | input | 1 | Serial output of user register 1 |
| userTdo2 | input | 1 | Serial output of user register 2 |
| cfgOutData | input | 1 | Serial configuration read stream |
| user1Sel | output | 1 | User instruction 1 active |
| user2Sel | output | 1 | User instruction 2 active |
| userReset | output | 1 | High in Test-Logic-Reset |
| userUpdate | output | 1 | High in Update-DR |
| userShift | output | 1 | High in Shift-DR |
| startupStep | output | 1 | One start-up advance per cycle |
| cfgInStrobe | output | 1 | tdi carries a configuration bit |

## Verification
A wrong state transition shows up within one or two test clocks. The next capture either loads the wrong register or shifts it at the wrong time, which misaligns every bit that follows on `tdo`, and `tdoEn` or the three state flags go wrong in the same cycle. A bad instruction decode shows up as a wrong bit count or pattern on the first data shift after Update-IR. A mis-wired boundary cell or update stage appears as a misplaced captured bit or a wrong `padOut`/`padOe` value directly after Update-DR. Random pad values and random reserved opcodes are used so that these faults are caught by more than one pattern.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tapState_e;

  localparam logic [4:0] OP_EXTEST   = 5'b00000;
  localparam logic [4:0] OP_SAMPLE   = 5'b00001;
  localparam logic [4:0] OP_USER1    = 5'b00010;
  localparam logic [4:0] OP_USER2    = 5'b00011;
  localparam logic [4:0] OP_CFGOUT   = 5'b00100;
  localparam logic [4:0] OP_CFGIN    = 5'b00101;
  localparam logic [4:0] OP_INTEST   = 5'b00111;
  localparam logic [4:0] OP_USERCODE = 5'b01000;
  localparam logic [4:0] OP_IDCODE   = 5'b01001;
  localparam logic [4:0] OP_HIZ      = 5'b01010;
  localparam logic [4:0] OP_JSTART   = 5'b01100;
  localparam logic [4:0] OP_BYPASS   = 5'b11111;

  // strobes from control to datapath
  typedef struct packed {
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic shiftIr;
    logic irTdo;
    logic selBound;
    logic selIdent;
    logic selUcode;
    logic selUser1;
    logic selUser2;
    logic selCfgOut;
    logic driveExt;
    logic hiZ;
  } scanCtl_t;

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic     tck,
  input  logic     trstN,
  input  logic     tms,
  input  logic     tdi,
  output scanCtl_t ctl,
  output logic     userReset,
  output logic     userUpdate,
  output logic     userShift,
  output logic     user1Sel,
  output logic     user2Sel,
  output logic     startupStep,
  output logic     cfgInStrobe
);

  tapState_e state, nextState;
  logic [4:0] irSr;
  logic [4:0] ir;

  always_comb begin
    unique case (state)
      TLR:    nextState = tms ? TLR    : RTI;
      RTI:    nextState = tms ? SEL_DR : RTI;
      SEL_DR: nextState = tms ? SEL_IR : CAP_DR;
      CAP_DR: nextState = tms ? EX1_DR : SH_DR;
      SH_DR:  nextState = tms ? EX1_DR : SH_DR;
      EX1_DR: nextState = tms ? UPD_DR : PAU_DR;
      PAU_DR: nextState = tms ? EX2_DR : PAU_DR;
      EX2_DR: nextState = tms ? UPD_DR : SH_DR;
      UPD_DR: nextState = tms ? SEL_DR : RTI;
      SEL_IR: nextState = tms ? TLR    : CAP_IR;
      CAP_IR: nextState = tms ? EX1_IR : SH_IR;
      SH_IR:  nextState = tms ? EX1_IR : SH_IR;
      EX1_IR: nextState = tms ? UPD_IR : PAU_IR;
      PAU_IR: nextState = tms ? EX2_IR : PAU_IR;
      EX2_IR: nextState = tms ? UPD_IR : SH_IR;
      UPD_IR: nextState = tms ? SEL_DR : RTI;
      default: nextState = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TLR;
    else        state <= nextState;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irSr <= OP_SAMPLE;
      ir   <= OP_IDCODE;
    end else begin
      if (state == CAP_IR)     irSr <= 5'b00001;
      else if (state == SH_IR) irSr <= {tdi, irSr[4:1]};
      if (state == TLR)         ir <= OP_IDCODE;
      else if (state == UPD_IR) ir <= irSr;
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.captureDr = (state == CAP_DR);
    ctl.shiftDr   = (state == SH_DR);
    ctl.updateDr  = (state == UPD_DR);
    ctl.shiftIr   = (state == SH_IR);
    ctl.irTdo     = irSr[0];
    case (ir)
      OP_EXTEST:   begin ctl.selBound = 1'b1; ctl.driveExt = 1'b1; end
      OP_SAMPLE:   ctl.selBound  = 1'b1;
      OP_INTEST:   ctl.selBound  = 1'b1;
      OP_USER1:    ctl.selUser1  = 1'b1;
      OP_USER2:    ctl.selUser2  = 1'b1;
      OP_CFGOUT:   ctl.selCfgOut = 1'b1;
      OP_USERCODE: ctl.selUcode  = 1'b1;
      OP_IDCODE:   ctl.selIdent  = 1'b1;
      OP_HIZ:      ctl.hiZ       = 1'b1;
      default:     ;
    endcase
  end

  assign userReset   = (state == TLR);
  assign userUpdate  = (state == UPD_DR);
  assign userShift   = (state == SH_DR);
  assign user1Sel    = (ir == OP_USER1);
  assign user2Sel    = (ir == OP_USER2);
  assign startupStep = (ir == OP_JSTART) && (state == SH_DR);
  assign cfgInStrobe = (ir == OP_CFGIN) && (state == SH_DR);

  // R1
  tlr_hold_chk: assert property (@(posedge tck) disable iff (!trstN)
    (state == TLR && tms) |=> (state == TLR));

  // R2
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trstN)
    (state == CAP_IR) |=> (irSr == 5'b00001));

  // R9
  user_flags_chk: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({userReset, userUpdate, userShift}));

endmodule

// File: rtl/scan_data.sv
module scan_data
  import scan_pkg::*;
#(
  parameter int          NUM_BIDIR    = 4,
  parameter int          NUM_INONLY   = 2,
  parameter logic [31:0] IDCODE_VAL   = 32'h1A2B_3C4D,
  parameter logic [31:0] USERCODE_VAL = 32'hC0DE_0042
) (
  input  logic                            tck,
  input  logic                            trstN,
  input  logic                            tdi,
  input  scanCtl_t                        ctl,
  input  logic [NUM_BIDIR+NUM_INONLY-1:0] padIn,
  input  logic [NUM_BIDIR-1:0]            coreOut,
  input  logic [NUM_BIDIR-1:0]            coreOe,
  input  logic                            userTdo1,
  input  logic                            userTdo2,
  input  logic                            cfgOutData,
  output logic [NUM_BIDIR-1:0]            padOut,
  output logic [NUM_BIDIR-1:0]            padOe,
  output logic                            tdo,
  output logic                            tdoEn
);

  localparam int CHAIN_LEN = 3 * NUM_BIDIR + NUM_INONLY;

  logic [CHAIN_LEN-1:0] chain, capVec;
  logic [NUM_BIDIR-1:0] updOut, updOe, chainOut, chainOe;
  logic [31:0]          wordSr;
  logic                 bypassReg, selBypass, drBit;

  for (genvar p = 0; p < NUM_BIDIR; p++) begin : g_bidir
    assign capVec[3*p]   = padIn[p];
    assign capVec[3*p+1] = coreOut[p];
    assign capVec[3*p+2] = coreOe[p];
    assign chainOut[p]   = chain[3*p+1];
    assign chainOe[p]    = chain[3*p+2];
    assign padOut[p]     = ctl.driveExt ? updOut[p] : coreOut[p];
    assign padOe[p]      = ctl.hiZ ? 1'b0 : (ctl.driveExt ? updOe[p] : coreOe[p]);
  end

  for (genvar k = 0; k < NUM_INONLY; k++) begin : g_inonly
    assign capVec[3*NUM_BIDIR+k] = padIn[NUM_BIDIR+k];
  end

  assign selBypass = ~(ctl.selBound | ctl.selIdent | ctl.selUcode |
                       ctl.selUser1 | ctl.selUser2 | ctl.selCfgOut);

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      chain     <= '0;
      wordSr    <= '0;
      bypassReg <= 1'b0;
      updOut    <= '0;
      updOe     <= '0;
    end else begin
      if (ctl.selBound) begin
        if (ctl.captureDr)    chain <= capVec;
        else if (ctl.shiftDr) chain <= {tdi, chain[CHAIN_LEN-1:1]};
        if (ctl.updateDr) begin
          updOut <= chainOut;
          updOe  <= chainOe;
        end
      end
      if (ctl.captureDr && ctl.selIdent)      wordSr <= IDCODE_VAL;
      else if (ctl.captureDr && ctl.selUcode) wordSr <= USERCODE_VAL;
      else if (ctl.shiftDr && (ctl.selIdent || ctl.selUcode))
        wordSr <= {tdi, wordSr[31:1]};
      if (ctl.captureDr)    bypassReg <= 1'b0;
      else if (ctl.shiftDr) bypassReg <= tdi;
    end
  end

  always_comb begin
    if (ctl.selBound)                     drBit = chain[0];
    else if (ctl.selIdent || ctl.selUcode) drBit = wordSr[0];
    else if (ctl.selUser1)                drBit = userTdo1;
    else if (ctl.selUser2)                drBit = userTdo2;
    else if (ctl.selCfgOut)               drBit = cfgOutData;
    else                                  drBit = bypassReg;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= ctl.shiftIr ? ctl.irTdo : drBit;
      tdoEn <= ctl.shiftIr | ctl.shiftDr;
    end
  end

  // R4
  bypass_delay_chk: assert property (@(posedge tck) disable iff (!trstN)
    (ctl.shiftDr && selBypass) |=> (bypassReg == $past(tdi)));

  // R7
  upd_load_chk: assert property (@(posedge tck) disable iff (!trstN)
    (ctl.updateDr && ctl.selBound) |=> (updOut == $past(chainOut) && updOe == $past(chainOe)));

  // R12
  tdoen_shift_chk: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn == (ctl.shiftIr || ctl.shiftDr));

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_pkg::*;
#(
  parameter int          NUM_BIDIR    = 4,
  parameter int          NUM_INONLY   = 2,
  parameter logic [31:0] IDCODE_VAL   = 32'h1A2B_3C4D,
  parameter logic [31:0] USERCODE_VAL = 32'hC0DE_0042
) (
  input  logic                            tck,
  input  logic                            trstN,
  input  logic                            tms,
  input  logic                            tdi,
  output logic                            tdo,
  output logic                            tdoEn,
  input  logic [NUM_BIDIR+NUM_INONLY-1:0] padIn,
  input  logic [NUM_BIDIR-1:0]            coreOut,
  input  logic [NUM_BIDIR-1:0]            coreOe,
  output logic [NUM_BIDIR-1:0]            padOut,
  output logic [NUM_BIDIR-1:0]            padOe,
  input  logic                            userTdo1,
  input  logic                            userTdo2,
  input  logic                            cfgOutData,
  output logic                            user1Sel,
  output logic                            user2Sel,
  output logic                            userReset,
  output logic                            userUpdate,
  output logic                            userShift,
  output logic                            startupStep,
  output logic                            cfgInStrobe
);

  scanCtl_t ctl;

  scan_ctrl u_ctrl (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .ctl(ctl),
    .userReset(userReset), .userUpdate(userUpdate), .userShift(userShift),
    .user1Sel(user1Sel), .user2Sel(user2Sel),
    .startupStep(startupStep), .cfgInStrobe(cfgInStrobe)
  );

  scan_data #(
    .NUM_BIDIR(NUM_BIDIR), .NUM_INONLY(NUM_INONLY),
    .IDCODE_VAL(IDCODE_VAL), .USERCODE_VAL(USERCODE_VAL)
  ) u_data (
    .tck(tck), .trstN(trstN), .tdi(tdi), .ctl(ctl),
    .padIn(padIn), .coreOut(coreOut), .coreOe(coreOe),
    .userTdo1(userTdo1), .userTdo2(userTdo2), .cfgOutData(cfgOutData),
    .padOut(padOut), .padOe(padOe), .tdo(tdo), .tdoEn(tdoEn)
  );

endmodule

// File: tb/scan_port_ctrl_tb.sv
module scan_port_ctrl_tb;

  localparam int CLK_P = 20;
  localparam int NB = 4;
  localparam int NI = 2;
  localparam int CL = 3 * NB + NI;
  localparam logic [31:0] ID_V = 32'h5E3C_9A71;
  localparam logic [31:0] UC_V = 32'h0BAD_F00D;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdoEn;
  logic [NB+NI-1:0] padIn = '0;
  logic [NB-1:0] coreOut = '0, coreOe = '0, padOut, padOe;
  logic userTdo1 = 1'b0, userTdo2 = 1'b0, cfgOutData = 1'b0;
  logic user1Sel, user2Sel, userReset, userUpdate, userShift, startupStep, cfgInStrobe;

  int checks = 0, failures = 0;
  int cntStep, cntCfg, cntUShift;
  logic enAll;
  logic sTdo, sEn;
  logic [4:0]  irCap;
  logic [63:0] din, got, expv;

  always #(CLK_P/2) tck = ~tck;

  scan_port_ctrl #(.NUM_BIDIR(NB), .NUM_INONLY(NI), .IDCODE_VAL(ID_V), .USERCODE_VAL(UC_V)) u_dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .padIn(padIn), .coreOut(coreOut), .coreOe(coreOe), .padOut(padOut), .padOe(padOe),
    .userTdo1(userTdo1), .userTdo2(userTdo2), .cfgOutData(cfgOutData),
    .user1Sel(user1Sel), .user2Sel(user2Sel), .userReset(userReset),
    .userUpdate(userUpdate), .userShift(userShift),
    .startupStep(startupStep), .cfgInStrobe(cfgInStrobe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one test clock: sample outputs after the falling edge, then drive inputs
  task automatic step(input logic tmsV, input logic tdiV);
    @(negedge tck); #1;
    sTdo = tdo; sEn = tdoEn;
    cntStep   += int'(startupStep);
    cntCfg    += int'(cfgInStrobe);
    cntUShift += int'(userShift);
    tms = tmsV; tdi = tdiV;
    @(posedge tck); #1;
  endtask

  task automatic shiftIr(input logic [4:0] code);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, code[i]);
      irCap[i] = sTdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic shiftDr(input int n, input logic [63:0] d);
    cntStep = 0; cntCfg = 0; cntUShift = 0; enAll = 1'b1; got = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, d[i]);
      got[i] = sTdo;
      enAll &= sEn;
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [63:0] expChain(input logic [NB+NI-1:0] pi,
                                           input logic [NB-1:0] co, input logic [NB-1:0] oe);
    logic [63:0] v = '0;
    for (int p = 0; p < NB; p++) begin
      v[3*p] = pi[p]; v[3*p+1] = co[p]; v[3*p+2] = oe[p];
    end
    for (int k = 0; k < NI; k++) v[3*NB+k] = pi[NB+k];
    return v;
  endfunction

  function automatic logic [63:0] bypassExp(input int n, input logic [63:0] d);
    logic [63:0] v = '0;
    for (int i = 1; i < n; i++) v[i] = d[i-1];
    return v;
  endfunction

  function automatic bit isReserved(input logic [4:0] c);
    return !(c inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd7, 5'd8,
                       5'd9, 5'd10, 5'd12, 5'd31});
  endfunction

  function automatic logic [NB-1:0] pick(input logic [63:0] d, input int off);
    logic [NB-1:0] v;
    for (int p = 0; p < NB; p++) v[p] = d[3*p+off];
    return v;
  endfunction

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_P * 3) trstN = 1'b1;
    #1;
    // reset state
    chk("R9 userReset after reset", userReset, 1);
    chk("R12 tdoEn low after reset", tdoEn, 0);
    step(0, 0);
    // R2 R5: identification selected after reset
    shiftDr(32, '0);
    chk("R5 idcode shifted", got, {32'h0, ID_V});
    chk("R12 tdoEn high while shifting", enAll, 1);
    step(0, 0);
    chk("R12 tdoEn low in idle", sEn, 0);

    shiftIr(5'b11111);
    chk("R2 IR capture pattern", irCap, 5'b00001);
    din = {$urandom, $urandom};
    shiftDr(16, din);
    chk("R4 bypass one-bit delay", got, bypassExp(16, din));
    chk("R9 userShift count", cntUShift, 16);

    // R3 reserved codes
    for (int r = 0; r < 6; r++) begin
      logic [4:0] c;
      c = 5'($urandom);
      while (!isReserved(c)) c = 5'($urandom);
      shiftIr(c);
      din = {$urandom, $urandom};
      shiftDr(8, din);
      chk("R3 reserved code selects bypass", got, bypassExp(8, din));
    end

    shiftIr(5'b01000);
    shiftDr(32, '0);
    chk("R5 usercode shifted", got, {32'h0, UC_V});

    // R6 sample, random pads
    shiftIr(5'b00001);
    for (int r = 0; r < 4; r++) begin
      padIn = ($urandom); coreOut = ($urandom); coreOe = ($urandom);
      expv = expChain(padIn, coreOut, coreOe);
      shiftDr(CL, '0);
      chk("R6 sample capture order", got, expv);
      chk("R7 padOut passes through", padOut, coreOut);
      chk("R7 padOe passes through", padOe, coreOe);
    end

    // R7 external test drive from update stage
    shiftIr(5'b00000);
    for (int r = 0; r < 3; r++) begin
      din = {$urandom, $urandom};
      expv = expChain(padIn, coreOut, coreOe);
      shiftDr(CL, din);
      chk("R6 extest capture", got, expv);
      chk("R7 extest padOut", padOut, pick(din, 1));
      chk("R7 extest padOe", padOe, pick(din, 2));
      coreOut = ~coreOut; #1;
      chk("R7 core ignored under extest", padOut, pick(din, 1));
    end
    shiftIr(5'b00111);
    chk("R7 intest no override", padOut, coreOut);
    shiftDr(CL, '0);
    chk("R6 intest capture", got, expChain(padIn, coreOut, coreOe));

    // R8 float pads
    coreOe = '1;
    shiftIr(5'b01010);
    chk("R8 all outputs floated", padOe, '0);
    din = {$urandom, $urandom};
    shiftDr(10, din);
    chk("R8 bypass under float", got, bypassExp(10, din));

    // R9 user registers
    shiftIr(5'b00010);
    chk("R9 user1Sel", {user1Sel, user2Sel}, 2'b10);
    userTdo1 = 1'b1; userTdo2 = 1'b0;
    step(1, 0); step(0, 0); step(0, 0);
    step(0, 0);
    chk("R9 tdo from user1", sTdo, 1);
    chk("R9 userShift in Shift-DR", userShift, 1);
    step(1, 0); step(1, 0);
    chk("R9 userUpdate in Update-DR", userUpdate, 1);
    step(0, 0);
    chk("R9 userUpdate low in idle", userUpdate, 0);
    shiftIr(5'b00011);
    shiftDr(6, '0);
    chk("R9 tdo from user2", got, 64'h0);
    userTdo2 = 1'b1;
    shiftDr(6, '0);
    chk("R9 tdo from user2 high", got, 64'h3F);

    // R10 start-up stepping
    shiftIr(5'b01100);
    shiftDr(11, '0);
    chk("R10 one step per shift cycle", cntStep, 11);
    shiftIr(5'b11111);
    shiftDr(5, '0);
    chk("R10 no steps under bypass", cntStep, 0);

    // R11 configuration paths
    shiftIr(5'b00101);
    din = {$urandom, $urandom};
    shiftDr(12, din);
    chk("R11 cfg-in strobe count", cntCfg, 12);
    chk("R11 cfg-in bypass path", got, bypassExp(12, din));
    shiftIr(5'b00100);
    cfgOutData = 1'b1;
    shiftDr(7, '0);
    chk("R11 cfg-out stream", got, 64'h7F);
    chk("R11 no cfg-in strobe under cfg-out", cntCfg, 0);

    // R12 tdo holds across rising edge
    shiftIr(5'b11111);
    step(1, 0); step(0, 0); step(0, 0);
    step(0, 1);
    chk("R12 first bypass bit", sTdo, 0);
    chk("R12 tdo stable after rising edge", tdo, 0);
    step(0, 1);
    chk("R12 tdo updated on falling edge", sTdo, 1);

    // R1 five TMS-high cycles from Shift-DR
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R1 reached Test-Logic-Reset", userReset, 1);
    step(0, 0);
    shiftDr(32, '0);
    chk("R2 IR reloaded identification", got, {32'h0, ID_V});

    // R1 asynchronous reset mid-operation
    shiftIr(5'b11111);
    step(1, 0); step(0, 0);
    @(negedge tck); #(CLK_P/4);
    trstN = 1'b0; #1;
    chk("R1 async reset", userReset, 1);
    #(CLK_P) trstN = 1'b1;
    step(0, 0);
    shiftDr(32, '0);
    chk("R1 identification after async reset", got, {32'h0, ID_V});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule